// File: doc/BRIEF.md
# LED Flash and Dimming Controller

This block drives a bank of LED outputs in parallel from a small set of memory-mapped configuration words. Every channel gets a 4-bit flash code, a 4-bit dimming level, a software enable bit, a hardware-ownership bit and a polarity bit. A shared prescaler makes a millisecond tick from the system clock. A shared nine-step counter provides the dimming pulse train. Each channel runs its own small state machine, which produces a square-wave blink with equal lit and unlit halves.

A channel goes dark when software disables it or when its hardware-ownership bit is set. The hardware activity sources are not part of this block and are treated as permanently inactive. The final active level is set per output by its polarity bit, and the outputs are registered.

Each channel state machine has four states. `CH_DARK`: the channel is disabled. `CH_STEADY`: the channel is lit without blinking. `CH_LIT`: the lit half of a blink. `CH_UNLIT`: the unlit half of a blink. The transitions are as follows:

- **enable-steady** (`CH_DARK` to `CH_STEADY`): the channel is enabled while it holds a non-blink code.
- **enable-blink** (`CH_DARK` to `CH_LIT`): the channel is enabled while it holds a blink code.
- **start-blink** (`CH_STEADY` to `CH_LIT`): a blink code is written while the channel is steady.
- **half-end** (`CH_LIT` and `CH_UNLIT` swap): a half period expires and the current code still blinks.
- **stop-blink** (`CH_LIT` or `CH_UNLIT` to `CH_STEADY`): a half period expires and the current code no longer blinks.
- **disable** (any state to `CH_DARK`): the channel is disabled.

Top module: `lamp_ctrl`

## Requirements
- R1: Channel n's field sits in bits [4*(n%8)+3 : 4*(n%8)] of word n/8. The four flash-code words are at addresses 0 to 3 and the four dimming-level words are at addresses 4 to 7.
- R2: Every register resets to 0. A write is stored at the clock edge where `bus_en` and `bus_we` are both high. A read presents the stored value on `bus_rdata` after the edge that accepts it. Addresses 11 to 15 read as 0.
- R3: Address 8 holds one software enable bit per channel. A channel whose bit is 0 stays inactive whatever its flash code and level.
- R4: Address 9 holds one polarity bit per channel: 1 means active-high and 0 means active-low. After reset every output reads 1.
- R5: Address 10 holds one hardware-ownership bit per channel. A channel whose bit is 1 stays inactive.
- R6: With a steady code, a channel at level L (0 to 8) is active for exactly L cycles out of any 9 consecutive cycles. Levels 9 to 15 are active on every cycle.
- R7: Flash codes 3, 4, 5, 6 and 7 blink with equal lit and unlit halves of 65, 140, 320, 640 and 1280 ticks. One tick lasts TICK_DIV clock cycles.
- R8: Codes 0, 1, 2 and 8 to 15 give a steady channel with no blinking.
- R9: A new flash code written during a blink is adopted only at the end of the current half period. That half therefore keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_out | output | 32 | Registered LED outputs, one per channel |

## Verification
The bench measures blink half periods edge to edge on the output, after the first edge of each run, for every blink code. A wrong tap or an off-by-one compare shows up directly as a wrong cycle count. It changes a code in the middle of a half and checks that the running half keeps its old length. A design that adopts codes at once would cut that half short. It sweeps dimming levels over whole multiples of the nine-step frame, including 0, 9 and an out-of-range value, where an inverted or unclamped compare gives the wrong count. It also checks field placement on a channel in the second word, along with polarity, enable and hardware-ownership masking.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    localparam int FIELD_W    = 4;
    localparam int LEVEL_FULL = 9;
    localparam int HALF_W     = 11;

    localparam int HALF_C3 = 65;
    localparam int HALF_C4 = 140;
    localparam int HALF_C5 = 320;
    localparam int HALF_C6 = 640;
    localparam int HALF_C7 = 1280;

    typedef enum logic [1:0] {
        CH_DARK,
        CH_STEADY,
        CH_LIT,
        CH_UNLIT
    } ch_state_e;

    function automatic logic is_blink(input logic [FIELD_W-1:0] c);
        return (c >= 4'd3) && (c <= 4'd7);
    endfunction

    function automatic logic [HALF_W-1:0] half_ticks(input logic [FIELD_W-1:0] c);
        logic [HALF_W-1:0] h;
        case (c)
            4'd3:    h = HALF_W'(HALF_C3);
            4'd4:    h = HALF_W'(HALF_C4);
            4'd5:    h = HALF_W'(HALF_C5);
            4'd6:    h = HALF_W'(HALF_C6);
            4'd7:    h = HALF_W'(HALF_C7);
            default: h = HALF_W'(1);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/lamp_timebase.sv
module lamp_timebase #(
    parameter int TICK_DIV = 250000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic                         ms_tick,
    output logic [lamp_pkg::FIELD_W-1:0] pwm_step
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int STEPS = lamp_pkg::LEVEL_FULL;

    logic [DIV_W-1:0] div_q;

    assign ms_tick = (div_q == DIV_W'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (ms_tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_step <= '0;
        end else if (pwm_step == lamp_pkg::FIELD_W'(STEPS - 1)) begin
            pwm_step <= '0;
        end else begin
            pwm_step <= pwm_step + lamp_pkg::FIELD_W'(1);
        end
    end

endmodule

// File: rtl/lamp_regs.sv
module lamp_regs #(
    parameter int NUM_LEDS = 32,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_en,
    input  logic                                  bus_we,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [DATA_W-1:0]                     bus_wdata,
    output logic [DATA_W-1:0]                     bus_rdata,
    output logic [NUM_LEDS*lamp_pkg::FIELD_W-1:0] flash_bits,
    output logic [NUM_LEDS*lamp_pkg::FIELD_W-1:0] bright_bits,
    output logic [NUM_LEDS-1:0]                   sw_bits,
    output logic [NUM_LEDS-1:0]                   pol_bits,
    output logic [NUM_LEDS-1:0]                   hwen_bits
);
    localparam int LANES    = DATA_W / lamp_pkg::FIELD_W;
    localparam int WORDS    = NUM_LEDS / LANES;
    localparam int A_BRIGHT = WORDS;
    localparam int A_SW     = 2 * WORDS;
    localparam int A_POL    = A_SW + 1;
    localparam int A_HWEN   = A_SW + 2;

    logic [DATA_W-1:0] flash_q  [WORDS];
    logic [DATA_W-1:0] bright_q [WORDS];
    logic [DATA_W-1:0] rd_mux;
    logic              wr;

    assign wr = bus_en && bus_we;

    for (genvar w = 0; w < WORDS; w++) begin : g_flat
        assign flash_bits[w*DATA_W +: DATA_W]  = flash_q[w];
        assign bright_bits[w*DATA_W +: DATA_W] = bright_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                flash_q[w]  <= '0;
                bright_q[w] <= '0;
            end
            sw_bits   <= '0;
            pol_bits  <= '0;
            hwen_bits <= '0;
        end else if (wr) begin
            for (int w = 0; w < WORDS; w++) begin
                if (bus_addr == ADDR_W'(w))            flash_q[w]  <= bus_wdata;
                if (bus_addr == ADDR_W'(A_BRIGHT + w)) bright_q[w] <= bus_wdata;
            end
            if (bus_addr == ADDR_W'(A_SW))   sw_bits   <= bus_wdata[NUM_LEDS-1:0];
            if (bus_addr == ADDR_W'(A_POL))  pol_bits  <= bus_wdata[NUM_LEDS-1:0];
            if (bus_addr == ADDR_W'(A_HWEN)) hwen_bits <= bus_wdata[NUM_LEDS-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == ADDR_W'(w))            rd_mux = flash_q[w];
            if (bus_addr == ADDR_W'(A_BRIGHT + w)) rd_mux = bright_q[w];
        end
        if (bus_addr == ADDR_W'(A_SW))   rd_mux = DATA_W'(sw_bits);
        if (bus_addr == ADDR_W'(A_POL))  rd_mux = DATA_W'(pol_bits);
        if (bus_addr == ADDR_W'(A_HWEN)) rd_mux = DATA_W'(hwen_bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_en && !bus_we) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/lamp_channel.sv
module lamp_channel (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ms_tick,
    input  logic [lamp_pkg::FIELD_W-1:0] pwm_step,
    input  logic                         enable,
    input  logic [lamp_pkg::FIELD_W-1:0] code,
    input  logic [lamp_pkg::FIELD_W-1:0] level,
    output logic                         lit
);
    import lamp_pkg::*;

    ch_state_e         st_q, st_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [FIELD_W-1:0] code_q, code_d;
    logic              half_end;
    logic              phase_on;
    logic              pwm_on;

    assign half_end = (cnt_q == half_ticks(code_q) - HALF_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CH_DARK;
            cnt_q  <= '0;
            code_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            code_q <= code_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        code_d = code_q;
        unique case (st_q)
            CH_DARK: begin
                if (enable) begin
                    st_d   = is_blink(code) ? CH_LIT : CH_STEADY;
                    cnt_d  = '0;
                    code_d = code;
                end
            end
            CH_STEADY: begin
                if (!enable) begin
                    st_d = CH_DARK;
                end else if (is_blink(code)) begin
                    st_d   = CH_LIT;
                    cnt_d  = '0;
                    code_d = code;
                end
            end
            CH_LIT, CH_UNLIT: begin
                if (!enable) begin
                    st_d = CH_DARK;
                end else if (ms_tick) begin
                    if (half_end) begin
                        cnt_d  = '0;
                        code_d = code;
                        if (!is_blink(code)) begin
                            st_d = CH_STEADY;
                        end else begin
                            st_d = (st_q == CH_LIT) ? CH_UNLIT : CH_LIT;
                        end
                    end else begin
                        cnt_d = cnt_q + HALF_W'(1);
                    end
                end
            end
            default: st_d = CH_DARK;
        endcase
    end

    always_comb begin
        phase_on = (st_q == CH_STEADY) || (st_q == CH_LIT);
        pwm_on   = (level >= FIELD_W'(LEVEL_FULL)) || (pwm_step < level);
        lit      = enable && phase_on && pwm_on;
    end

endmodule

// File: rtl/lamp_ctrl.sv
module lamp_ctrl #(
    parameter int NUM_LEDS = 32,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int TICK_DIV = 250000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_LEDS-1:0] led_out
);
    localparam int FW = lamp_pkg::FIELD_W;

    logic [NUM_LEDS*FW-1:0] flash_bits;
    logic [NUM_LEDS*FW-1:0] bright_bits;
    logic [NUM_LEDS-1:0]    sw_bits;
    logic [NUM_LEDS-1:0]    pol_bits;
    logic [NUM_LEDS-1:0]    hwen_bits;
    logic [NUM_LEDS-1:0]    ch_on;
    logic                   ms_tick;
    logic [FW-1:0]          pwm_step;

    lamp_regs #(
        .NUM_LEDS(NUM_LEDS),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .flash_bits (flash_bits),
        .bright_bits(bright_bits),
        .sw_bits    (sw_bits),
        .pol_bits   (pol_bits),
        .hwen_bits  (hwen_bits)
    );

    lamp_timebase #(
        .TICK_DIV(TICK_DIV)
    ) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .pwm_step(pwm_step)
    );

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_ch
        lamp_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ms_tick (ms_tick),
            .pwm_step(pwm_step),
            .enable  (sw_bits[i] & ~hwen_bits[i]),
            .code    (flash_bits[FW*i +: FW]),
            .level   (bright_bits[FW*i +: FW]),
            .lit     (ch_on[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_out <= '1;
        end else begin
            led_out <= ~(pol_bits ^ ch_on);
        end
    end

endmodule

// File: rtl/lamp_ctrl_chk.sv
module lamp_ctrl_chk #(
    parameter int NUM_LEDS = 32,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_LEDS-1:0] led_out,
    input logic [NUM_LEDS-1:0] sw_bits,
    input logic [NUM_LEDS-1:0] pol_bits,
    input logic [NUM_LEDS-1:0] hwen_bits,
    input logic [3:0]          level0
);
    localparam int WORDS = NUM_LEDS / (DATA_W / 4);
    localparam int A_SW  = 2 * WORDS;
    localparam int A_POL = A_SW + 1;

    assert_rd_sw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == ADDR_W'(A_SW))
        |=> bus_rdata == DATA_W'($past(sw_bits)));

    assert_wr_pol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == ADDR_W'(A_POL))
        |=> pol_bits == $past(bus_wdata[NUM_LEDS-1:0]));

    assert_zero_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (level0 == 4'd0) |=> led_out[0] == !$past(pol_bits[0]));

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_mask
        assert_sw_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !sw_bits[i] |=> led_out[i] == !$past(pol_bits[i]));

        assert_hw_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hwen_bits[i] |=> led_out[i] == !$past(pol_bits[i]));
    end

endmodule

bind lamp_ctrl lamp_ctrl_chk #(
    .NUM_LEDS(NUM_LEDS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .led_out  (led_out),
    .sw_bits  (sw_bits),
    .pol_bits (pol_bits),
    .hwen_bits(hwen_bits),
    .level0   (bright_bits[3:0])
);

// File: tb/sim_lamp_ctrl.sv
`timescale 1ns/1ps
module sim_lamp_ctrl;

    localparam int TICK   = 4;
    localparam int WD_MAX = 150000;

    // dimming vectors: {level[3:0], expected active cycles in 90 [7:0]}
    localparam logic [11:0] DIM_VEC [6] = '{12'h000, 12'h10A, 12'h428,
                                            12'h850, 12'h95A, 12'hC5A};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] led_out;

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;

    always #2 clk = ~clk;

    lamp_ctrl #(.TICK_DIV(TICK)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .led_out  (led_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_MAX) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_MAX);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic count_level(input int ch, input logic v, input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (led_out[ch] === v) c++;
        end
    endtask

    task automatic wait_edge(input int ch, output longint stamp);
        logic v;
        v = led_out[ch];
        stamp = -1;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (led_out[ch] !== v) begin
                stamp = cyc;
                break;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        int c;
        longint s0, s1, s2, s3;
        int halves [5] = '{65, 140, 320, 640, 1280};

        idle(3);
        check("R4 reset outputs", led_out, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        idle(2);
        bus_read(4'd0, rd);
        check("R2 reset value", rd, 0);

        bus_write(4'd1, 32'hA5C3_1E07);
        bus_read(4'd1, rd);
        check("R2 read back", rd, 32'hA5C3_1E07);
        bus_read(4'd15, rd);
        check("R2 unmapped read", rd, 0);
        bus_write(4'd1, 32'h0);

        // R1: channel 13 sits in level word 1, bits 23:20
        bus_write(4'd9, 32'hFFFF_FFFF);
        bus_write(4'd8, 32'hFFFF_FFFF);
        bus_write(4'd5, 32'h0090_0000);
        idle(4);
        check("R1 field placement", led_out, 32'h0000_2000);
        bus_write(4'd5, 32'h0);
        bus_write(4'd8, 32'h1);

        // R6: dimming vectors on channel 0
        foreach (DIM_VEC[i]) begin
            bus_write(4'd4, {28'h0, DIM_VEC[i][11:8]});
            idle(3);
            count_level(0, 1'b1, 90, c);
            check($sformatf("R6 level %0d", DIM_VEC[i][11:8]), c, DIM_VEC[i][7:0]);
        end

        // R3: enable bit cleared at full level
        bus_write(4'd4, 32'h9);
        bus_write(4'd8, 32'h0);
        idle(2);
        count_level(0, 1'b1, 18, c);
        check("R3 disabled dark", c, 0);

        // R4: active-low polarity
        bus_write(4'd9, 32'h0);
        idle(2);
        check("R4 active-low idle", led_out[0], 1);
        bus_write(4'd8, 32'h1);
        idle(3);
        count_level(0, 1'b0, 18, c);
        check("R4 active-low lit", c, 18);
        bus_write(4'd9, 32'hFFFF_FFFF);

        // R5: hardware ownership masks the channel
        bus_write(4'd10, 32'h1);
        idle(2);
        count_level(0, 1'b1, 18, c);
        check("R5 hw owned dark", c, 0);
        bus_read(4'd10, rd);
        check("R5 hw bit read", rd, 1);
        bus_write(4'd10, 32'h0);

        // R8: non-blink codes stay steady
        bus_write(4'd0, 32'h1);
        idle(3);
        count_level(0, 1'b1, 600, c);
        check("R8 code 1 steady", c, 600);
        bus_write(4'd0, 32'h9);
        idle(3);
        count_level(0, 1'b1, 600, c);
        check("R8 code 9 steady", c, 600);

        // R7: each blink code, two full halves after a sync edge
        for (int k = 0; k < 5; k++) begin
            bus_write(4'd0, 32'(k + 3));
            wait_edge(0, s0);
            wait_edge(0, s1);
            wait_edge(0, s2);
            check($sformatf("R7 code %0d first half", k + 3), s1 - s0, TICK * halves[k]);
            check($sformatf("R7 code %0d second half", k + 3), s2 - s1, TICK * halves[k]);
        end

        // R9: code change mid-half waits for the boundary
        bus_write(4'd0, 32'h3);
        wait_edge(0, s0);
        wait_edge(0, s1);
        idle(40);
        bus_write(4'd0, 32'h5);
        wait_edge(0, s2);
        wait_edge(0, s3);
        check("R9 running half kept", s2 - s1, TICK * 65);
        check("R9 new half adopted", s3 - s2, TICK * 320);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule